// File: doc/BRIEF.md
# Dual-Latch Input Capture Unit

This block copies the value of a free-running source timer into one of two capture latches, named latch A and latch B. An external pin can start a capture, and so can a write to a software trigger field. Each external pin goes through a two-flop synchronizer and then through an optional noise filter before its edge detector. The filter has a selectable sample rate, and the edge polarity is chosen per pin.

Every capture takes the full timer word in a single cycle and sets that latch's interrupt request. The request stays set until software clears it with a write-one-to-clear. A status word reports both requests and which latch captured most recently. When both latches capture in the same cycle, that report resolves to latch B.

A stop-mode flag halts the filter sample clock. With the filter bypassed, pin edges are still taken in stop mode, so a capture can serve as a wake-up source.

Top module: `dual_capture_unit`

## Requirements
- R1: A software trigger write with data bit 0 set loads `capValA` with the `timerCount` present at the clock edge of that write. `irqReq[0]` is high from the next cycle.
- R2: A software trigger write with data bit 1 set loads `capValB` in the same way and sets `irqReq[1]`.
- R3: With `filtSel` = 00 (filter bypassed), a qualifying pin edge first sampled at clock edge e1 makes the latch capture the `timerCount` present at edge e4.
- R4: `edgeSel[i]` = 0 selects rising edges on `capPin[i]` and 1 selects falling edges. The opposite edge captures nothing.
- R5: For `filtSel` 01, 10 and 11, the filter samples every clock, every 4th clock and every 16th clock. A new level is accepted only after three equal consecutive samples. With 01, a clean edge first sampled at e1 captures the count present at e7. A pulse shorter than two sample periods is rejected.
- R6: While `stopMode` is high and `filtSel` is not 00, pin edges are ignored. With `filtSel` = 00, pin edges are still captured in stop mode.
- R7: `capStatus` bit 0 mirrors `irqReq[0]` and bit 1 mirrors `irqReq[1]`. Bit 4 shows the latch of the most recent capture (0 = A, 1 = B). All other bits read 0.
- R8: When both latches capture in the same cycle, each latch gets the same count and `capStatus[4]` becomes 1. This holds for two software bits together and for a pin edge on A together with a software trigger on B.
- R9: A write to `flagClrWe` clears each request whose data bit is 1. A capture on that latch in the same cycle wins, and the flag stays set.
- R10: A latch holds its value in every cycle without a capture on it.
- R11: After reset, both latches, both requests and the status word are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| timerCount | input | 16 | Source timer value |
| capPin | input | 2 | External capture pins (bit 0 to A, bit 1 to B) |
| edgeSel | input | 2 | Per-pin polarity, 1 = falling |
| filtSel | input | 2 | Filter sample rate, 00 = bypass |
| stopMode | input | 1 | Halts the filter sample clock |
| swTrigWe | input | 1 | Software trigger write strobe |
| swTrigData | input | 2 | Software trigger bits (bit 0 A, bit 1 B) |
| flagClrWe | input | 1 | Request clear write strobe |
| flagClrData | input | 2 | Write-one-to-clear bits |
| capValA | output | 16 | Latch A value |
| capValB | output | 16 | Latch B value |
| capStatus | output | 8 | Status word |
| irqReq | output | 2 | Capture interrupt requests |

## Verification
The bench aims at same-cycle collisions. It fires both software bits together, and it lines up a pin edge on A with a software write on B. A design that lets the status bit follow latch A, or that drops one of the two captures, shows a wrong bit 4 or a stale latch. It also clears a flag in the same cycle as a capture, which exposes a clear that wins over the set. Glitch pulses shorter than the filter window, edges of the wrong polarity, and edges in stop mode with the filter running must leave both requests at 0. The exact capture cycle is checked for the bypassed filter and for the one-clock filter, so an extra or missing register stage shows up as an off-by-one count.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef struct packed {
    logic       capA;
    logic       capB;
    logic [1:0] clr;
  } capStrobe_t;
endpackage

// File: rtl/cap_filter.sv
module cap_filter (
  input  logic clk,
  input  logic rstN,
  input  logic pin,
  input  logic sampleEn,
  input  logic bypass,
  input  logic fallSel,
  output logic edgePulse
);
  logic [1:0] syncQ;
  logic [2:0] hist;
  logic       lvl;
  logic       update;
  logic       cand;

  always_comb begin
    if (bypass) begin
      update = 1'b1;
      cand   = syncQ[1];
    end else begin
      update = sampleEn && (hist == 3'b111 || hist == 3'b000);
      cand   = hist[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= '0;
      hist      <= '0;
      lvl       <= 1'b0;
      edgePulse <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], pin};
      if (sampleEn) hist <= {hist[1:0], syncQ[1]};
      if (update) lvl <= cand;
      edgePulse <= update && (cand != lvl) && (cand == !fallSel);
    end
  end
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int DIV_MID  = 4,
  parameter int DIV_SLOW = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] filtSel,
  input  logic       stopMode,
  input  logic [1:0] edgePulse,
  input  logic       swTrigWe,
  input  logic [1:0] swTrigData,
  input  logic       flagClrWe,
  input  logic [1:0] flagClrData,
  output logic       sampleEn,
  output capStrobe_t strobe
);
  localparam int PRE_W = $clog2(DIV_SLOW);
  logic [PRE_W-1:0] preCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (!stopMode) preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    unique case (filtSel)
      2'b01:   sampleEn = !stopMode;
      2'b10:   sampleEn = !stopMode && (preCnt % DIV_MID == DIV_MID - 1);
      2'b11:   sampleEn = !stopMode && (preCnt == PRE_W'(DIV_SLOW - 1));
      default: sampleEn = 1'b0;
    endcase
    strobe.capA = edgePulse[0] || (swTrigWe && swTrigData[0]);
    strobe.capB = edgePulse[1] || (swTrigWe && swTrigData[1]);
    strobe.clr  = flagClrWe ? flagClrData : 2'b00;
  end
endmodule

// File: rtl/cap_datapath.sv
module cap_datapath
  import cap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] timerCount,
  input  capStrobe_t       strobe,
  output logic [CNT_W-1:0] capValA,
  output logic [CNT_W-1:0] capValB,
  output logic [7:0]       capStatus,
  output logic [1:0]       irqReq
);
  logic lastB;
  logic [1:0] capHit;

  assign capHit = {strobe.capB, strobe.capA};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capValA <= '0;
      capValB <= '0;
      lastB   <= 1'b0;
    end else begin
      if (strobe.capA) capValA <= timerCount;
      if (strobe.capB) capValB <= timerCount;
      if (strobe.capA || strobe.capB) lastB <= strobe.capB;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) irqReq[i] <= 1'b0;
      else if (capHit[i]) irqReq[i] <= 1'b1;
      else if (strobe.clr[i]) irqReq[i] <= 1'b0;
    end
  end

  assign capStatus = {3'b000, lastB, 2'b00, irqReq};
endmodule

// File: rtl/dual_capture_unit.sv
module dual_capture_unit
  import cap_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DIV_MID  = 4,
  parameter int DIV_SLOW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] timerCount,
  input  logic [1:0]       capPin,
  input  logic [1:0]       edgeSel,
  input  logic [1:0]       filtSel,
  input  logic             stopMode,
  input  logic             swTrigWe,
  input  logic [1:0]       swTrigData,
  input  logic             flagClrWe,
  input  logic [1:0]       flagClrData,
  output logic [CNT_W-1:0] capValA,
  output logic [CNT_W-1:0] capValB,
  output logic [7:0]       capStatus,
  output logic [1:0]       irqReq
);
  logic [1:0] edgePulse;
  logic       sampleEn;
  capStrobe_t strobe;

  for (genvar i = 0; i < 2; i++) begin : g_filt
    cap_filter u_filt (
      .clk(clk), .rstN(rstN), .pin(capPin[i]), .sampleEn(sampleEn),
      .bypass(filtSel == 2'b00), .fallSel(edgeSel[i]), .edgePulse(edgePulse[i])
    );
  end

  cap_ctrl #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .filtSel(filtSel), .stopMode(stopMode),
    .edgePulse(edgePulse), .swTrigWe(swTrigWe), .swTrigData(swTrigData),
    .flagClrWe(flagClrWe), .flagClrData(flagClrData),
    .sampleEn(sampleEn), .strobe(strobe)
  );

  cap_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .timerCount(timerCount), .strobe(strobe),
    .capValA(capValA), .capValB(capValB), .capStatus(capStatus), .irqReq(irqReq)
  );
endmodule

// File: rtl/cap_checker.sv
module cap_checker
  import cap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] timerCount,
  input logic [1:0]       filtSel,
  input logic             stopMode,
  input capStrobe_t       strobe,
  input logic [1:0]       edgePulse,
  input logic [CNT_W-1:0] capValA,
  input logic [CNT_W-1:0] capValB,
  input logic [7:0]       capStatus,
  input logic [1:0]       irqReq
);
  AST_CAP_A_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capA |=> capValA == $past(timerCount)); // R1
  AST_CAP_B_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capB |=> capValB == $past(timerCount)); // R2
  AST_STOP_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (stopMode && filtSel != 2'b00) |=> edgePulse == 2'b00); // R6
  AST_STATUS_RSVD: assert property (@(posedge clk) disable iff (!rstN)
    capStatus[7:5] == 3'b000 && capStatus[3:2] == 2'b00 && capStatus[1:0] == irqReq); // R7
  AST_BOTH_TO_B: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capA && strobe.capB) |=> capStatus[4]); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capA |=> irqReq[0]); // R9
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clr[1] && !strobe.capB) |=> !irqReq[1]); // R9
  AST_HOLD_A: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capA |=> $stable(capValA)); // R10
  AST_HOLD_B: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capB |=> $stable(capValB)); // R10
endmodule

bind dual_capture_unit cap_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .timerCount(timerCount), .filtSel(filtSel),
  .stopMode(stopMode), .strobe(strobe), .edgePulse(edgePulse),
  .capValA(capValA), .capValB(capValB), .capStatus(capStatus), .irqReq(irqReq)
);

// File: tb/dual_capture_unit_tb.sv
module dual_capture_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] tcnt = '0;
  logic [1:0]  capPin = '0, edgeSel = '0, filtSel = '0;
  logic        stopMode = 1'b0, swTrigWe = 1'b0, flagClrWe = 1'b0;
  logic [1:0]  swTrigData = '0, flagClrData = '0;
  logic [15:0] capValA, capValB;
  logic [7:0]  capStatus;
  logic [1:0]  irqReq;
  int checks = 0, fails = 0;
  logic [15:0] mA = '0, mB = '0;
  logic        fA = 0, fB = 0, mLast = 0;

  always #2 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 16'd1;

  dual_capture_unit u_dut (
    .clk(clk), .rstN(rstN), .timerCount(tcnt), .capPin(capPin), .edgeSel(edgeSel),
    .filtSel(filtSel), .stopMode(stopMode), .swTrigWe(swTrigWe), .swTrigData(swTrigData),
    .flagClrWe(flagClrWe), .flagClrData(flagClrData), .capValA(capValA),
    .capValB(capValB), .capStatus(capStatus), .irqReq(irqReq)
  );

  function automatic logic [7:0] expStatus(logic a, logic b, logic last);
    return {3'b000, last, 2'b00, b, a};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearAll();
    flagClrWe = 1; flagClrData = 2'b11; cyc(1); flagClrWe = 0; flagClrData = 0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] x;
    void'($urandom(32'h5eed));
    cyc(3); rstN = 1; cyc(1);
    chk("R11 capValA", capValA, 0); chk("R11 capValB", capValB, 0);
    chk("R11 status", capStatus, 0); chk("R11 irq", irqReq, 0);

    // R1/R2/R7/R9/R10 random phase against model
    for (int i = 0; i < 400; i++) begin
      logic [15:0] t;
      logic sA, sB, cA, cB;
      swTrigWe = ($urandom % 3) == 0; swTrigData = 2'($urandom);
      flagClrWe = ($urandom % 3) == 0; flagClrData = 2'($urandom);
      t = tcnt;
      sA = swTrigWe && swTrigData[0]; sB = swTrigWe && swTrigData[1];
      cA = flagClrWe && flagClrData[0]; cB = flagClrWe && flagClrData[1];
      cyc(1);
      if (sA) mA = t;
      if (sB) mB = t;
      fA = sA ? 1'b1 : (cA ? 1'b0 : fA);
      fB = sB ? 1'b1 : (cB ? 1'b0 : fB);
      if (sA || sB) mLast = sB;
      chk("R1/R10 capValA", capValA, mA);
      chk("R2/R10 capValB", capValB, mB);
      chk("R7/R8/R9 status", capStatus, expStatus(fA, fB, mLast));
    end
    swTrigWe = 0; flagClrWe = 0; clearAll();

    // R8 both software bits together
    swTrigWe = 1; swTrigData = 2'b11; x = tcnt; cyc(1); swTrigWe = 0; swTrigData = 0;
    chk("R8 sim A", capValA, x); chk("R8 sim B", capValB, x);
    chk("R8 sim status", capStatus, expStatus(1, 1, 1));
    // R9 clear in same cycle as capture on A
    flagClrWe = 1; flagClrData = 2'b11; swTrigWe = 1; swTrigData = 2'b01; cyc(1);
    flagClrWe = 0; swTrigWe = 0; swTrigData = 0;
    chk("R9 set wins", irqReq, 2'b01);
    clearAll();

    // R3 bypassed filter, rising on A
    capPin[0] = 1; x = tcnt; cyc(5);
    chk("R3 value", capValA, x + 16'd3); chk("R3 irq", irqReq, 2'b01);
    chk("R7 last A", capStatus[4], 0);
    capPin[0] = 0; cyc(6); chk("R4 falling ignored", irqReq, 2'b01);
    clearAll();

    // R4 falling polarity on B
    edgeSel = 2'b10; cyc(2);
    capPin[1] = 1; cyc(8); chk("R4 rise ignored B", irqReq, 2'b00);
    capPin[1] = 0; x = tcnt; cyc(5);
    chk("R4 fall value B", capValB, x + 16'd3); chk("R4 fall irq", irqReq, 2'b10);
    clearAll(); edgeSel = 2'b00; cyc(2);

    // R8 pin edge on A aligned with software write on B
    capPin[0] = 1; x = tcnt; cyc(3);
    swTrigWe = 1; swTrigData = 2'b10; cyc(1); swTrigWe = 0; swTrigData = 0;
    chk("R8 mixed A", capValA, x + 16'd3); chk("R8 mixed B", capValB, x + 16'd3);
    chk("R8 mixed status", capStatus, expStatus(1, 1, 1));
    capPin[0] = 0; cyc(6); clearAll();

    // R5 one-clock filter exact latency
    filtSel = 2'b01; cyc(6);
    capPin[0] = 1; x = tcnt; cyc(8);
    chk("R5 filt value", capValA, x + 16'd6); chk("R5 filt irq", irqReq, 2'b01);
    capPin[0] = 0; cyc(10); clearAll();
    // R5 glitch rejected with 4-clock sampling
    filtSel = 2'b10; cyc(10);
    capPin[0] = 1; cyc(2); capPin[0] = 0; cyc(40);
    chk("R5 glitch rejected", irqReq, 2'b00);
    // R5 slow filter accepts long pulse
    filtSel = 2'b11; cyc(40);
    capPin[1] = 1; cyc(90);
    chk("R5 slow accepted", irqReq, 2'b10);
    capPin[1] = 0; cyc(90); clearAll();

    // R6 stop with running filter ignores pins
    filtSel = 2'b01; stopMode = 1; cyc(2);
    capPin[0] = 1; cyc(20); chk("R6 stop ignored", irqReq, 2'b00);
    capPin[0] = 0; cyc(6);
    // R6 stop with bypass still captures
    filtSel = 2'b00; cyc(4);
    capPin[0] = 1; x = tcnt; cyc(5);
    chk("R6 stop bypass value", capValA, x + 16'd3); chk("R6 stop bypass irq", irqReq, 2'b01);
    capPin[0] = 0; stopMode = 0; cyc(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule